// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits between two processors that share a 2K x 8 memory. Each side has its own active-low chip enable, output enable and read/write strobe, an address and a data byte. Both sides may read and write any location. The two highest addresses double as mailboxes. When one side writes its partner's mailbox, the partner's interrupt output goes low. The partner clears that interrupt by reading the mailbox.

The location just below the top belongs to the left side. The right side writes it to signal the left side, and the left side clears the flag by accessing it with output enable low. The top location belongs to the right side in the same way. The mailbox bytes are plain memory contents, so the message travels with the interrupt. Each side has an active-low busy input. While it is low, that side can neither change a flag nor write the memory. An external arbiter drives it.

Top module: `dual_mailbox_irq`

## Requirements
- R1: After reset both interrupt outputs (`lIntN`, `rIntN`) are high (not pending) and both read-data outputs are 0.
- R2: A side reads when its chip enable is low and its read/write is high. The stored byte appears on its read-data output on the clock after the address is presented. A side writes when its chip enable and read/write are both low.
- R3: If one side reads an address in the same cycle as the other side writes it, the reader gets the byte stored before that write.
- R4: A right-side write to address 0x7FE (`rCeN`=0, `rRwN`=0, `rBusyN`=1) drives `lIntN` low after that clock edge.
- R5: The left side clears `lIntN` by accessing 0x7FE with `lCeN`=0 and `lOeN`=0 and `lBusyN`=1, whatever the value of `lRwN`. With `lOeN` high, the flag stays set.
- R6: A left-side write to 0x7FF drives `rIntN` low. A right-side access to 0x7FF with `rCeN`=0, `rOeN`=0 and `rBusyN`=1 clears it, and with `rOeN` high the flag stays set.
- R7: The bytes at 0x7FE and 0x7FF are written and read like any other location.
- R8: While a side's busy input is low, its sets and clears leave the interrupt flags unchanged.
- R9: While a side's busy input is low, its writes leave the memory unchanged.
- R10: With its chip enable high, a side makes no access. The memory, the flags and its read-data output all stay unchanged.
- R11: If a set and a clear reach the same flag in the same cycle, the flag ends up set (low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lCeN | input | 1 | Left chip enable, active low |
| lOeN | input | 1 | Left output enable, active low |
| lRwN | input | 1 | Left read (1) / write (0) |
| lAddr | input | 11 | Left address |
| lWrData | input | 8 | Left write data |
| lBusyN | input | 1 | Left busy, active low, blocks writes and flag changes |
| lRdData | output | 8 | Left read data, registered |
| lIntN | output | 1 | Left interrupt, active low |
| rCeN | input | 1 | Right chip enable, active low |
| rOeN | input | 1 | Right output enable, active low |
| rRwN | input | 1 | Right read (1) / write (0) |
| rAddr | input | 11 | Right address |
| rWrData | input | 8 | Right write data |
| rBusyN | input | 1 | Right busy, active low |
| rRdData | output | 8 | Right read data, registered |
| rIntN | output | 1 | Right interrupt, active low |

## Verification
Two functions can land on the same mailbox flag in one cycle: the sender's write sets it and the owner's read clears it. The bench drives a right-side write to 0x7FE in the same clock as a left-side read of 0x7FE with output enable low. It then expects `lIntN` to be low and the left read to return the byte stored before that write. The bench also overlaps a read and a write to an ordinary address, and expects the old byte to come back first and the new byte on the next read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W_DEF = 11;
  localparam int DATA_W_DEF = 8;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic wrL;
    logic wrR;
    logic rdL;
    logic rdR;
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_control.sv
module mbx_control
  import mbx_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lCeN,
  input  logic              lOeN,
  input  logic              lRwN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusyN,
  input  logic              rCeN,
  input  logic              rOeN,
  input  logic              rRwN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusyN,
  output mbxStrobe_t        strobe,
  output logic              lIntN,
  output logic              rIntN
);
  // Mailbox owned by the left side sits one below the top; the right side owns the top.
  localparam logic [ADDR_W-1:0] L_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};

  logic lSel, rSel, lWrite, rWrite;
  logic setL, clrL, setR, clrR;

  always_comb begin
    lSel   = !lCeN;
    rSel   = !rCeN;
    lWrite = lSel && !lRwN && lBusyN;
    rWrite = rSel && !rRwN && rBusyN;
    strobe.wrL = lWrite;
    strobe.wrR = rWrite;
    strobe.rdL = lSel && lRwN;
    strobe.rdR = rSel && rRwN;
    setL = rWrite && (rAddr == L_BOX);
    clrL = lSel && !lOeN && lBusyN && (lAddr == L_BOX);
    setR = lWrite && (lAddr == R_BOX);
    clrR = rSel && !rOeN && rBusyN && (rAddr == R_BOX);
  end

  // Set has priority over clear so a fresh message is never lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lIntN <= 1'b1;
      rIntN <= 1'b1;
    end else begin
      if (setL)      lIntN <= 1'b0;
      else if (clrL) lIntN <= 1'b1;
      if (setR)      rIntN <= 1'b0;
      else if (clrR) rIntN <= 1'b1;
    end
  end

  p_set_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rCeN && !rRwN && rBusyN && rAddr == L_BOX) |=> !lIntN);

  p_clear_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lCeN && !lOeN && lBusyN && lAddr == L_BOX &&
     !(!rCeN && !rRwN && rBusyN && rAddr == L_BOX)) |=> lIntN);

  p_set_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lCeN && !lRwN && lBusyN && lAddr == R_BOX) |=> !rIntN);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lCeN && rCeN) |=> ($stable(lIntN) && $stable(rIntN)));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lBusyN && !rBusyN) |=> ($stable(lIntN) && $stable(rIntN)));
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mbxStrobe_t        strobe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic [DATA_W-1:0] rRdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Both writes in one cycle to one address: the left side lands last.
  always_ff @(posedge clk) begin
    if (strobe.wrR) mem[rAddr] <= rWrData;
    if (strobe.wrL) mem[lAddr] <= lWrData;
  end

  // Registered reads see the contents from before this edge's writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lRdData <= '0;
      rRdData <= '0;
    end else begin
      if (strobe.rdL) lRdData <= mem[lAddr];
      if (strobe.rdR) rRdData <= mem[rAddr];
    end
  end

  p_left_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.rdL |=> $stable(lRdData));

  p_right_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.rdR |=> $stable(rRdData));

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.wrL && strobe.rdL) && !(strobe.wrR && strobe.rdR));
endmodule

// File: rtl/dual_mailbox_irq.sv
module dual_mailbox_irq
  import mbx_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lCeN,
  input  logic              lOeN,
  input  logic              lRwN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic              lBusyN,
  output logic [DATA_W-1:0] lRdData,
  output logic              lIntN,
  input  logic              rCeN,
  input  logic              rOeN,
  input  logic              rRwN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  input  logic              rBusyN,
  output logic [DATA_W-1:0] rRdData,
  output logic              rIntN
);
  mbxStrobe_t strobe;

  mbx_control #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .lCeN(lCeN), .lOeN(lOeN), .lRwN(lRwN), .lAddr(lAddr), .lBusyN(lBusyN),
    .rCeN(rCeN), .rOeN(rOeN), .rRwN(rRwN), .rAddr(rAddr), .rBusyN(rBusyN),
    .strobe(strobe), .lIntN(lIntN), .rIntN(rIntN)
  );

  mbx_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .lAddr(lAddr), .lWrData(lWrData), .rAddr(rAddr), .rWrData(rWrData),
    .lRdData(lRdData), .rRdData(rRdData)
  );
endmodule

// File: tb/dual_mailbox_irq_tb_top.sv
module dual_mailbox_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lCeN = 1, lOeN = 1, lRwN = 1, lBusyN = 1;
  logic rCeN = 1, rOeN = 1, rRwN = 1, rBusyN = 1;
  logic [10:0] lAddr = '0, rAddr = '0;
  logic [7:0] lWrData = '0, rWrData = '0;
  logic [7:0] lRdData, rRdData;
  logic lIntN, rIntN;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_mailbox_irq dut_i (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    lCeN = 1; lOeN = 1; lRwN = 1; lBusyN = 1;
    rCeN = 1; rOeN = 1; rRwN = 1; rBusyN = 1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic lSet(logic ce, logic oe, logic rw, logic [10:0] a, logic [7:0] d, logic b);
    lCeN = ce; lOeN = oe; lRwN = rw; lAddr = a; lWrData = d; lBusyN = b;
  endtask

  task automatic rSet(logic ce, logic oe, logic rw, logic [10:0] a, logic [7:0] d, logic b);
    rCeN = ce; rOeN = oe; rRwN = rw; rAddr = a; rWrData = d; rBusyN = b;
  endtask

  task automatic t_reset();
    chk("R1 lIntN", {7'd0, lIntN}, 8'h01);
    chk("R1 rIntN", {7'd0, rIntN}, 8'h01);
    chk("R1 lRdData", lRdData, 8'h00);
    chk("R1 rRdData", rRdData, 8'h00);
  endtask

  task automatic t_read_write();
    lSet(0, 1, 0, 11'h123, 8'hA5, 1); tick();
    rSet(0, 0, 1, 11'h123, 8'h00, 1); tick();
    chk("R2 right reads left byte", rRdData, 8'hA5);
    rSet(0, 1, 0, 11'h055, 8'h3C, 1); tick();
    lSet(0, 0, 1, 11'h055, 8'h00, 1); tick();
    chk("R2 left reads right byte", lRdData, 8'h3C);
  endtask

  task automatic t_old_data();
    lSet(0, 1, 0, 11'h200, 8'h11, 1); tick();
    lSet(0, 1, 0, 11'h200, 8'h22, 1);
    rSet(0, 0, 1, 11'h200, 8'h00, 1); tick();
    chk("R3 overlap returns old byte", rRdData, 8'h11);
    rSet(0, 0, 1, 11'h200, 8'h00, 1); tick();
    chk("R3 next read returns new byte", rRdData, 8'h22);
  endtask

  task automatic t_left_irq();
    rSet(0, 1, 0, 11'h7FE, 8'h5A, 1); tick();
    chk("R4 lIntN set", {7'd0, lIntN}, 8'h00);
    chk("R4 rIntN untouched", {7'd0, rIntN}, 8'h01);
    lSet(0, 0, 1, 11'h7FE, 8'h00, 1); tick();
    chk("R7 left mailbox byte", lRdData, 8'h5A);
    chk("R5 read clears lIntN", {7'd0, lIntN}, 8'h01);
    rSet(0, 1, 0, 11'h7FE, 8'h5B, 1); tick();
    lSet(0, 0, 0, 11'h7FE, 8'h61, 1); tick();
    chk("R5 write access also clears", {7'd0, lIntN}, 8'h01);
    lSet(0, 0, 1, 11'h7FE, 8'h00, 1); tick();
    chk("R7 mailbox written by owner", lRdData, 8'h61);
  endtask

  task automatic t_right_irq();
    lSet(0, 1, 0, 11'h7FF, 8'hC3, 1); tick();
    chk("R6 rIntN set", {7'd0, rIntN}, 8'h00);
    rSet(0, 1, 1, 11'h7FF, 8'h00, 1); tick();
    chk("R6 oe high keeps rIntN", {7'd0, rIntN}, 8'h00);
    chk("R7 right mailbox byte", rRdData, 8'hC3);
    rSet(0, 0, 1, 11'h7FF, 8'h00, 1); tick();
    chk("R6 read clears rIntN", {7'd0, rIntN}, 8'h01);
  endtask

  task automatic t_busy();
    lSet(0, 1, 0, 11'h300, 8'h77, 1); tick();
    lSet(0, 1, 0, 11'h300, 8'h88, 0); tick();
    lSet(0, 0, 1, 11'h300, 8'h00, 1); tick();
    chk("R9 busy write blocked", lRdData, 8'h77);
    rSet(0, 1, 0, 11'h7FE, 8'h44, 0); tick();
    chk("R8 busy set blocked", {7'd0, lIntN}, 8'h01);
    rSet(0, 1, 0, 11'h7FE, 8'h45, 1); tick();
    lSet(0, 0, 1, 11'h7FE, 8'h00, 0); tick();
    chk("R8 busy clear blocked", {7'd0, lIntN}, 8'h00);
    lSet(0, 0, 1, 11'h7FE, 8'h00, 1); tick();
    chk("R8 clear after busy released", {7'd0, lIntN}, 8'h01);
    chk("R9 data after busy", lRdData, 8'h45);
  endtask

  task automatic t_ce_high();
    rSet(0, 0, 1, 11'h123, 8'h00, 1); tick();
    rSet(1, 1, 0, 11'h7FE, 8'hEE, 1); tick();
    chk("R10 deselected write no flag", {7'd0, lIntN}, 8'h01);
    rSet(1, 0, 1, 11'h7FF, 8'h00, 1); tick();
    chk("R10 deselected read holds data", rRdData, 8'hA5);
    lSet(0, 0, 1, 11'h7FE, 8'h00, 1); tick();
    chk("R10 deselected write no store", lRdData, 8'h45);
  endtask

  task automatic t_set_wins();
    rSet(0, 1, 0, 11'h7FE, 8'h99, 1);
    lSet(0, 0, 1, 11'h7FE, 8'h00, 1); tick();
    chk("R11 set beats clear", {7'd0, lIntN}, 8'h00);
    chk("R3 overlap on mailbox old byte", lRdData, 8'h45);
    lSet(0, 0, 1, 11'h7FE, 8'h00, 1); tick();
    chk("R11 later clear works", {7'd0, lIntN}, 8'h01);
    chk("R7 new message", lRdData, 8'h99);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_read_write();
    t_old_data();
    t_left_irq();
    t_right_irq();
    t_busy();
    t_ce_high();
    t_set_wins();
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
    end
  end
endmodule